// File: doc/BRIEF.md
# Up/Down Potentiometer Step Sequencer

This block is the host-side driver for a digital potentiometer that is moved by three wires: an active-low select, an active-low step strobe and a direction level. Software or a control FSM hands it one command at a time over a valid/ready handshake. A command carries a direction, a step count from 0 to 31 and a save flag. The sequencer then produces the whole line waveform. It selects the part and sets up the direction. It issues the requested number of step pulses, each with a minimum low and high phase. Finally it deselects the part.

The save flag decides how the sequence ends, and only through the order in which the lines are released. To commit the wiper position, the step line is left high while select rises, and select is then held high for the long commit time. To skip the commit, the step line is held low while select rises, and only the short deselect time is kept.

Every minimum time is given in nanoseconds and turned into clock cycles by rounding up against a clock-frequency parameter, with a floor of one cycle. A single-cycle done pulse ends each command. Busy stays high, and ready stays low, until the deselect interval has fully elapsed.

Top module: `pot_step_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sel_n and step_n are 1, cmd_ready is 1, busy is 0 and done is 0.
- R2: A command is taken on a rising clock edge with cmd_valid and cmd_ready both high. In the next cycle busy is 1 and cmd_ready is 0. cmd_ready stays 0 while busy is 1, so cmd_valid held during a command starts nothing.
- R3: The number of falling edges of step_n equals cmd_steps (0 to 31). Each of them occurs while sel_n is 0.
- R4: sel_n is 0 for at least SEL_CYC = max(ceil(T_SEL_SETUP_NS*CLK_MHZ/1000), ceil(T_DIR_HOLD_NS*CLK_MHZ/1000)) cycles before the first falling edge of step_n.
- R5: dir_up (1 = up, 0 = down) takes the command's cmd_up value at least DIR_CYC cycles before the first falling edge of step_n. It does not change while sel_n is 0 once stepping has begun.
- R6: Every low phase of step_n lasts at least LOW_CYC cycles. Every high phase between two steps lasts at least HIGH_CYC cycles.
- R7: After the last edge of step_n, the line rests for at least REST_CYC cycles before sel_n rises.
- R8: With cmd_save = 1, step_n is 1 when sel_n rises. Busy then stays high for at least SAVE_CYC cycles after that rise.
- R9: With cmd_save = 0, step_n is 0 when sel_n rises. Busy then stays high for at least NOSAVE_CYC cycles after that rise.
- R10: Each command yields exactly one done pulse, one cycle wide, in the last cycle before busy falls.
- R11: A zero step count with save set selects and releases the part with step_n high throughout, which is a commit-only cycle. A zero step count without save leaves sel_n and step_n untouched and still gives the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_up | input | 1 | Direction of the command, 1 = up |
| cmd_steps | input | STEP_W | Number of step pulses |
| cmd_save | input | 1 | Commit the position at the end |
| sel_n | output | 1 | Active-low select line to the potentiometer |
| step_n | output | 1 | Step strobe, a falling edge moves the wiper |
| dir_up | output | 1 | Direction line |
| busy | output | 1 | Command in progress, including the deselect time |
| done | output | 1 | One-cycle pulse at the end of each command |

## Verification
The hardest cases to reach are the ends of the release path: the last step of a no-save burst, where step_n must stay low into the select release, and the commit-only cycle, which enters release without any pulse. The bench reaches them with separate directed commands: one step without save, a full 31-step burst with save, and zero steps with and without save. A monitor timestamps every line edge so that each minimum interval is checked against cycle counts computed in the bench. A further command holds cmd_valid through its whole run to show that nothing is accepted while busy.

// File: rtl/pot_seq_pkg.sv
package pot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_SETUP,
        ST_DIR_SETUP,
        ST_INC_LOW,
        ST_INC_HIGH,
        ST_RELEASE,
        ST_DESELECT,
        ST_DONE
    } seq_state_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pot_cycle_timer.sv
module pot_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pot_step_count.sv
module pot_step_count #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)
            rem_d = load_val;
        else if (dec && rem_q != '0)
            rem_d = rem_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign is_zero = (rem_q == '0);
    assign is_one  = (rem_q == W'(1));

endmodule

// File: rtl/pot_step_sequencer.sv
module pot_step_sequencer
    import pot_seq_pkg::*;
#(
    parameter int STEP_W          = 5,
    parameter int CLK_MHZ         = 125,
    parameter int T_SEL_SETUP_NS  = 100,
    parameter int T_DIR_HOLD_NS   = 100,
    parameter int T_DIR_SETUP_NS  = 100,
    parameter int T_LOW_NS        = 1000,
    parameter int T_HIGH_NS       = 1000,
    parameter int T_REST_NS       = 1000,
    parameter int T_SAVE_NS       = 10_000_000,
    parameter int T_NOSAVE_NS     = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_up,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_save,
    output logic              sel_n,
    output logic              step_n,
    output logic              dir_up,
    output logic              busy,
    output logic              done
);
    // select setup also covers the direction-change hold after the last strobe rise
    localparam int SEL_CYC    = imax(ns_to_cycles(T_SEL_SETUP_NS, CLK_MHZ),
                                     ns_to_cycles(T_DIR_HOLD_NS, CLK_MHZ));
    localparam int DIR_CYC    = ns_to_cycles(T_DIR_SETUP_NS, CLK_MHZ);
    localparam int LOW_CYC    = ns_to_cycles(T_LOW_NS, CLK_MHZ);
    localparam int HIGH_CYC   = ns_to_cycles(T_HIGH_NS, CLK_MHZ);
    localparam int REST_CYC   = ns_to_cycles(T_REST_NS, CLK_MHZ);
    localparam int SAVE_CYC   = ns_to_cycles(T_SAVE_NS, CLK_MHZ);
    localparam int NOSAVE_CYC = ns_to_cycles(T_NOSAVE_NS, CLK_MHZ);
    localparam int MAX_CYC    = imax(imax(imax(SEL_CYC, DIR_CYC), imax(LOW_CYC, HIGH_CYC)),
                                     imax(REST_CYC, imax(SAVE_CYC, NOSAVE_CYC)));
    localparam int TW         = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e state;
        logic       sel_n;
        logic       step_n;
        logic       dir;
        logic       up;
        logic       save;
        logic       done;
    } seq_regs_t;

    seq_regs_t       r_d, r_q;
    logic            tmr_load, tmr_expired;
    logic [TW-1:0]   tmr_val;
    logic            cnt_load, cnt_dec, cnt_zero, cnt_one;

    pot_cycle_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pot_step_count #(.W(STEP_W)) u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cmd_steps),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    cnt_load = 1'b1;
                    r_d.up   = cmd_up;
                    r_d.save = cmd_save;
                    if (cmd_steps == '0 && !cmd_save) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.sel_n = 1'b0;
                        r_d.state = ST_SEL_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(SEL_CYC - 1);
                    end
                end
            end
            ST_SEL_SETUP: begin
                if (tmr_expired) begin
                    r_d.dir   = r_q.up;
                    r_d.state = ST_DIR_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(DIR_CYC - 1);
                end
            end
            ST_DIR_SETUP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (cnt_zero) begin
                        r_d.state = ST_RELEASE;
                        tmr_val   = TW'(REST_CYC - 1);
                    end else begin
                        r_d.step_n = 1'b0;
                        r_d.state  = ST_INC_LOW;
                        tmr_val    = TW'(LOW_CYC - 1);
                    end
                end
            end
            ST_INC_LOW: begin
                if (tmr_expired) begin
                    cnt_dec  = 1'b1;
                    tmr_load = 1'b1;
                    if (cnt_one && !r_q.save) begin
                        r_d.state = ST_RELEASE;
                        tmr_val   = TW'(REST_CYC - 1);
                    end else begin
                        r_d.step_n = 1'b1;
                        r_d.state  = ST_INC_HIGH;
                        tmr_val    = TW'(HIGH_CYC - 1);
                    end
                end
            end
            ST_INC_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (cnt_zero) begin
                        r_d.state = ST_RELEASE;
                        tmr_val   = TW'(REST_CYC - 1);
                    end else begin
                        r_d.step_n = 1'b0;
                        r_d.state  = ST_INC_LOW;
                        tmr_val    = TW'(LOW_CYC - 1);
                    end
                end
            end
            ST_RELEASE: begin
                if (tmr_expired) begin
                    r_d.sel_n = 1'b1;
                    r_d.state = ST_DESELECT;
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.save ? TW'(SAVE_CYC - 1) : TW'(NOSAVE_CYC - 1);
                end
            end
            ST_DESELECT: begin
                if (tmr_expired) begin
                    r_d.step_n = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_DONE;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sel_n: 1'b1, step_n: 1'b1, dir: 1'b0,
                     up: 1'b0, save: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_n     = r_q.sel_n;
    assign step_n    = r_q.step_n;
    assign dir_up    = r_q.dir;
    assign done      = r_q.done;
    assign busy      = (r_q.state != ST_IDLE);
    assign cmd_ready = (r_q.state == ST_IDLE);

    assert_step_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_n) |-> !sel_n);

    assert_dir_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_n |-> $stable(dir_up));

    assert_low_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_INC_LOW && !tmr_expired) |=> (r_q.state == ST_INC_LOW && !step_n));

    assert_release_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (step_n == r_q.save));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/pot_step_sequencer_tb.sv
`timescale 1ns/1ps
module pot_step_sequencer_tb;

    localparam int MHZ       = 125;
    localparam int SAVE_NS   = 4000;
    localparam int SEL_CYC   = 13;   // ceil(100*125/1000)
    localparam int DIR_CYC   = 13;
    localparam int LOW_CYC   = 125;
    localparam int HIGH_CYC  = 125;
    localparam int REST_CYC  = 125;
    localparam int SAVE_CYC  = 500;  // ceil(4000*125/1000)
    localparam int NOSV_CYC  = 32;   // ceil(250*125/1000)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_up = 1'b0;
    logic [4:0] cmd_steps = '0;
    logic       cmd_save = 1'b0;
    logic       cmd_ready, sel_n, step_n, dir_up, busy, done;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pot_step_sequencer #(.CLK_MHZ(MHZ), .T_SAVE_NS(SAVE_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_up(cmd_up), .cmd_steps(cmd_steps), .cmd_save(cmd_save),
        .sel_n(sel_n), .step_n(step_n), .dir_up(dir_up), .busy(busy), .done(done)
    );

    // edge monitor
    int cyc = 0;
    logic p_sel = 1'b1, p_step = 1'b1, p_dir = 1'b0, p_busy = 1'b0;
    int falls, fall_unsel, t_sel_fall, t_first_fall, t_fall, t_rise, t_last_edge;
    int t_dir, t_sel_rise, t_busy_fall, t_done, done_cnt, dir_bad, ready_bad;
    int min_low, min_high;
    bit sel_fell, have_rise, dir_changed, lvl_at_rise, dir_at_fall;

    always @(negedge clk) begin
        cyc++;
        if (p_sel && !sel_n) begin t_sel_fall = cyc; sel_fell = 1; end
        if (p_step && !step_n) begin
            falls++;
            if (sel_n) fall_unsel++;
            if (falls == 1) t_first_fall = cyc;
            else if (have_rise && (cyc - t_rise) < min_high) min_high = cyc - t_rise;
            t_fall = cyc; t_last_edge = cyc; dir_at_fall = dir_up;
        end
        if (!p_step && step_n && !sel_n) begin
            if ((cyc - t_fall) < min_low) min_low = cyc - t_fall;
            t_rise = cyc; have_rise = 1; t_last_edge = cyc;
        end
        if (p_dir != dir_up) begin
            t_dir = cyc; dir_changed = 1;
            if (!sel_n && falls > 0) dir_bad++;
        end
        if (!p_sel && sel_n) begin t_sel_rise = cyc; lvl_at_rise = step_n; end
        if (p_busy && !busy) t_busy_fall = cyc;
        if (done) begin done_cnt++; t_done = cyc; end
        if (cmd_ready && busy) ready_bad++;
        p_sel = sel_n; p_step = step_n; p_dir = dir_up; p_busy = busy;
    end

    task automatic clear_mon();
        falls = 0; fall_unsel = 0; t_sel_fall = 0; t_first_fall = 0; t_fall = 0; t_rise = 0;
        t_last_edge = 0; t_dir = 0; t_sel_rise = 0; t_busy_fall = 0; t_done = 0;
        done_cnt = 0; dir_bad = 0; ready_bad = 0; min_low = 1 << 30; min_high = 1 << 30;
        sel_fell = 0; have_rise = 0; dir_changed = 0; lvl_at_rise = 0; dir_at_fall = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // issue one command and wait until the sequencer is idle again
    task automatic run_cmd(input bit up, input int steps, input bit save, input bit hold);
        @(negedge clk); #1;
        clear_mon();
        cmd_up = up; cmd_steps = 5'(steps); cmd_save = save; cmd_valid = 1'b1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk); #1;
        chk(busy && !cmd_ready, "R2 busy after accept", busy, 1);
        if (!hold) cmd_valid = 1'b0;
        else begin cmd_steps = 5'd7; cmd_up = ~up; end
        while (done_cnt == 0) begin @(negedge clk); #1; end
        cmd_valid = 1'b0;
        repeat (3) begin @(negedge clk); #1; end
    endtask

    task automatic check_cmd(input bit up, input int steps, input bit save);
        bit active;
        active = !(steps == 0 && !save);
        chk(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
        chk(t_busy_fall == t_done + 1, "R10 done before busy falls", t_busy_fall - t_done, 1);
        chk(falls == steps, "R3 step count", falls, steps);
        chk(fall_unsel == 0, "R3 steps while selected", fall_unsel, 0);
        chk(ready_bad == 0, "R2 ready low while busy", ready_bad, 0);
        chk(dir_bad == 0, "R5 direction steady", dir_bad, 0);
        chk(busy == 0 && cmd_ready == 1, "R2 idle again", busy, 0);
        if (!active) begin
            chk(sel_fell == 0, "R11 no select", sel_fell, 0);
        end else begin
            chk(sel_fell == 1, "R11 select seen", sel_fell, 1);
            chk(dir_up == up, "R5 direction value", dir_up, up);
            if (steps > 0) begin
                chk(t_first_fall - t_sel_fall >= SEL_CYC, "R4 select setup",
                    t_first_fall - t_sel_fall, SEL_CYC);
                chk(dir_at_fall == up, "R5 direction at step", dir_at_fall, up);
                if (dir_changed)
                    chk(t_first_fall - t_dir >= DIR_CYC, "R5 direction setup",
                        t_first_fall - t_dir, DIR_CYC);
                chk(min_low >= LOW_CYC, "R6 low width", min_low, LOW_CYC);
                if (steps > 1)
                    chk(min_high >= HIGH_CYC, "R6 high width", min_high, HIGH_CYC);
                chk(t_sel_rise - t_last_edge >= REST_CYC, "R7 rest before release",
                    t_sel_rise - t_last_edge, REST_CYC);
            end else begin
                chk(lvl_at_rise == 1, "R11 commit-only level", lvl_at_rise, 1);
            end
            if (save) begin
                chk(lvl_at_rise == 1, "R8 step high at release", lvl_at_rise, 1);
                chk(t_busy_fall - t_sel_rise >= SAVE_CYC, "R8 commit hold",
                    t_busy_fall - t_sel_rise, SAVE_CYC);
            end else begin
                chk(lvl_at_rise == 0, "R9 step low at release", lvl_at_rise, 0);
                chk(t_busy_fall - t_sel_rise >= NOSV_CYC, "R9 deselect hold",
                    t_busy_fall - t_sel_rise, NOSV_CYC);
            end
        end
    endtask

    task automatic test_reset();
        chk(sel_n == 1, "R1 sel_n reset", sel_n, 1);
        chk(step_n == 1, "R1 step_n reset", step_n, 1);
        chk(cmd_ready == 1, "R1 ready reset", cmd_ready, 1);
        chk(busy == 0, "R1 busy reset", busy, 0);
        chk(done == 0, "R1 done reset", done, 0);
    endtask

    task automatic test_up_save();      run_cmd(1, 5, 1, 0);  check_cmd(1, 5, 1);  endtask
    task automatic test_down_nosave();  run_cmd(0, 3, 0, 0);  check_cmd(0, 3, 0);  endtask
    task automatic test_single_nosave();run_cmd(1, 1, 0, 0);  check_cmd(1, 1, 0);  endtask
    task automatic test_full_burst();   run_cmd(1, 31, 1, 0); check_cmd(1, 31, 1); endtask
    task automatic test_commit_only();  run_cmd(0, 0, 1, 0);  check_cmd(0, 0, 1);  endtask
    task automatic test_zero_nosave();  run_cmd(1, 0, 0, 0);  check_cmd(1, 0, 0);  endtask
    task automatic test_busy_ignore();  run_cmd(0, 4, 1, 1);  check_cmd(0, 4, 1);  endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 test_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        test_reset();
        test_up_save();
        test_down_nosave();
        test_single_nosave();
        test_full_burst();
        test_commit_only();
        test_zero_nosave();
        test_busy_ignore();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

endmodule